// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller for one successive-approximation analog-to-digital conversion. The comparator and the capacitor DAC sit outside the block. A start request opens a conversion, and the conversion runs through three ordered phases. In the sample phase the input is held. In the conversion phase the block drives a 10-bit trial code to the DAC, resolves one bit per prescaled clock from the MSB down, and takes its decision from a single comparator bit. A short calibration window follows the bit decisions. The last phase is a one-cycle result write.

A busy flag covers the whole conversion. A sticky interrupt flag reports completion and stays set until it is cleared. A two-bit prescaler select picks the length of one conversion step, which is 1, 2, 4 or 8 system clocks. The select is captured when a conversion starts. In continuous mode a new conversion begins straight after the result write. In single mode the sequencer goes back to idle. Successive conversions alternate between an offset calibration window and a linearity calibration window. These windows are shown on two stub outputs.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o, irq_o, sample_o, cal_offset_o and cal_lin_o are 0, and result_o and dac_code_o are 0.
- R2: A start_i seen in idle sets busy_o at that same clock edge. sample_o is high for the first 4·D cycles of the conversion, where D = 2^presc_sel_i.
- R3: dac_code_o carries the trial code only during the conversion phase, and its first trial is 10'h200. The comparator input cmp_i = 1 means the analog input is at or above the trial code, and the trial bit is then kept. With an ideal comparator the result equals the input code.
- R4: busy_o stays high for exactly 16·D system cycles: 4·D for sampling, 10·D for the bits and 2·D for calibration.
- R5: busy_o falls and irq_o rises at the same clock edge.
- R6: result_o takes the new code one cycle after busy_o falls, and it holds its value at all other times.
- R7: In the last 2·D busy cycles exactly one of cal_offset_o and cal_lin_o is high. The first conversion after reset uses offset calibration, and the type alternates with each conversion.
- R8: With cont_i = 1 at the result write, busy_o rises again one cycle after it fell. With cont_i = 0 the block stays idle.
- R9: irq_o stays set until irq_clr_i is applied. If a clear and a set arrive in the same cycle, irq_o stays set.
- R10: A start_i pulse while busy_o is high has no effect: no further conversion follows in single mode.
- R11: A change of presc_sel_i during a conversion leaves that conversion's length unchanged and applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion start request |
| cont_i | input | 1 | 1 = continuous mode, 0 = single mode |
| presc_sel_i | input | 2 | Step length select, D = 2^value system clocks |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above the trial code |
| dac_code_o | output | 10 | Trial code for the capacitor DAC |
| sample_o | output | 1 | High during the sample phase |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Sticky completion flag |
| result_o | output | 10 | Last conversion result |
| cal_offset_o | output | 1 | Offset calibration window |
| cal_lin_o | output | 1 | Linearity calibration window |

## Verification
Each result has a fixed due time, counted from the clock edge that accepts start_i. busy_o falls and irq_o rises 16·D edges later. result_o changes one edge after that. In continuous mode busy_o rises again on that same later edge. The sample and calibration windows last 4·D and 2·D cycles inside the busy window. A monitor samples on the falling clock edge. It counts busy cycles, sample cycles and calibration cycles against the item the driver queued, and it checks the interrupt flag at the busy fall and the result on the next falling edge. Any checks tied to a precise edge, such as a clear that coincides with a set, are driven on falling edges that are counted back from the start.

// File: rtl/sar_seq_pkg.sv
// Package: shared phase encoding for the SAR conversion sequencer.
// Assumes: every sequencer module imports this one type.
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_CONV,
        PH_CAL,
        PH_WRITE
    } phase_e;

endpackage

// File: rtl/sar_tick_gen.sv
// Module: step-rate tick generator.
// Produces one tick every 2^sel system clocks. The select is captured on
// restart_i, so it changes only at a conversion start.
// Assumes: restart_i pulses for one cycle at the edge that enters sampling.
module sar_tick_gen #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int MAX_SHIFT = (1 << SEL_W) - 1;
    localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic [CNT_W-1:0] last_cnt;

    assign period   = (CNT_W+1)'(1) << sel_q;
    assign last_cnt = period[CNT_W-1:0] - CNT_W'(1);
    assign tick_o   = (cnt_q == last_cnt);

    // Capture the select at restart and count system clocks within one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            sel_q <= sel_i;
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // The step counter never runs past the selected period.
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);

    // The captured select changes only at a conversion start.
    assert_sel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> $stable(sel_q));

endmodule

// File: rtl/sar_phase_ctrl.sv
// Module: phase sequencer for sample, conversion, calibration and write.
// Owns the busy flag, the sticky interrupt flag and the calibration toggle.
// Assumes: tick_i comes from sar_tick_gen and was restarted by restart_o.
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int SAMPLE_TICKS = 4,
    parameter int BITS         = 10,
    parameter int CAL_TICKS    = 2,
    parameter int STEP_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              irq_clr_i,
    input  logic              tick_i,
    output phase_e            phase_o,
    output logic [STEP_W-1:0] step_o,
    output logic              restart_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic              sample_o,
    output logic              cal_offset_o,
    output logic              cal_lin_o
);

    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              irq_q;
    logic              cal_lin_q;
    logic              last_step;
    logic              irq_set;

    assign last_step = tick_i && (step_q == '0);
    assign restart_o = ((phase_q == PH_IDLE) && start_i) ||
                       ((phase_q == PH_WRITE) && cont_i);
    assign irq_set   = (phase_q == PH_CAL) && last_step;

    // Advance through the phases and count steps down within each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            step_q    <= '0;
            busy_q    <= 1'b0;
            cal_lin_q <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (restart_o) begin
                        phase_q <= PH_SAMPLE;
                        step_q  <= STEP_W'(SAMPLE_TICKS - 1);
                        busy_q  <= 1'b1;
                    end
                end
                PH_SAMPLE: begin
                    if (last_step) begin
                        phase_q <= PH_CONV;
                        step_q  <= STEP_W'(BITS - 1);
                    end else if (tick_i) begin
                        step_q <= step_q - STEP_W'(1);
                    end
                end
                PH_CONV: begin
                    if (last_step) begin
                        phase_q <= PH_CAL;
                        step_q  <= STEP_W'(CAL_TICKS - 1);
                    end else if (tick_i) begin
                        step_q <= step_q - STEP_W'(1);
                    end
                end
                PH_CAL: begin
                    if (last_step) begin
                        phase_q   <= PH_WRITE;
                        busy_q    <= 1'b0;
                        cal_lin_q <= ~cal_lin_q;
                    end else if (tick_i) begin
                        step_q <= step_q - STEP_W'(1);
                    end
                end
                PH_WRITE: begin
                    if (restart_o) begin
                        phase_q <= PH_SAMPLE;
                        step_q  <= STEP_W'(SAMPLE_TICKS - 1);
                        busy_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Sticky interrupt flag; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_set | (irq_q & ~irq_clr_i);
        end
    end

    assign phase_o      = phase_q;
    assign step_o       = step_q;
    assign busy_o       = busy_q;
    assign irq_o        = irq_q;
    assign sample_o     = (phase_q == PH_SAMPLE);
    assign cal_offset_o = (phase_q == PH_CAL) && !cal_lin_q;
    assign cal_lin_o    = (phase_q == PH_CAL) && cal_lin_q;

    // An accepted start in idle enters sampling with busy already high.
    assert_start_enters_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) && start_i |=> busy_q && (phase_q == PH_SAMPLE));

    // The interrupt flag is high in the cycle in which busy falls.
    assert_irq_at_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> irq_q);

    // At most one calibration window is shown at a time.
    assert_cal_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_offset_o, cal_lin_o}));

    // Without a clear the interrupt flag stays set.
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !irq_clr_i |=> irq_q);

    // Busy never rises outside a restart.
    assert_no_spurious_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_o |=> !$rose(busy_q));

endmodule

// File: rtl/sar_approx_reg.sv
// Module: successive-approximation register and result register.
// Loads the MSB trial at the end of sampling, then on each conversion tick
// fixes the current bit from the comparator and raises the next lower bit.
// Assumes: step_i counts BITS-1 down to 0 through the conversion phase.
module sar_approx_reg
    import sar_seq_pkg::*;
#(
    parameter int BITS   = 10,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              cmp_i,
    output logic [BITS-1:0]   trial_o,
    output logic [BITS-1:0]   result_o
);

    localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

    logic [BITS-1:0] sar_q;
    logic [BITS-1:0] result_q;
    logic [BITS-1:0] sar_next;

    // Decide the current bit and put the next lower bit on trial.
    always_comb begin
        sar_next = sar_q;
        for (int b = 0; b < BITS; b++) begin
            if (b == int'(step_i)) begin
                sar_next[b] = cmp_i;
            end else if (b + 1 == int'(step_i)) begin
                sar_next[b] = 1'b1;
            end
        end
    end

    // Update the trial register per step and capture the result in the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q    <= '0;
            result_q <= '0;
        end else begin
            unique case (phase_i)
                PH_SAMPLE: if (tick_i && (step_i == '0)) sar_q <= MSB_ONLY;
                PH_CONV:   if (tick_i) sar_q <= sar_next;
                PH_WRITE:  result_q <= sar_q;
                default:   ;
            endcase
        end
    end

    assign trial_o  = (phase_i == PH_CONV) ? sar_q : '0;
    assign result_o = result_q;

    // A trial code in the conversion phase always has a bit set.
    assert_trial_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_CONV) |-> (sar_q != '0));

    // The result register changes only out of the write phase.
    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != PH_WRITE) |=> $stable(result_q));

endmodule

// File: rtl/sar_seq.sv
// Module: top of the SAR conversion sequencer.
// Ties the tick generator, the phase controller and the approximation register
// together. Assumes the comparator is settled within one step.
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int BITS         = 10,
    parameter int SEL_W        = 2,
    parameter int SAMPLE_TICKS = 4,
    parameter int CAL_TICKS    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [SEL_W-1:0] presc_sel_i,
    input  logic             irq_clr_i,
    input  logic             cmp_i,
    output logic [BITS-1:0]  dac_code_o,
    output logic             sample_o,
    output logic             busy_o,
    output logic             irq_o,
    output logic [BITS-1:0]  result_o,
    output logic             cal_offset_o,
    output logic             cal_lin_o
);

    localparam int STEP_MAX0 = (BITS > SAMPLE_TICKS) ? BITS : SAMPLE_TICKS;
    localparam int STEP_MAX  = (STEP_MAX0 > CAL_TICKS) ? STEP_MAX0 : CAL_TICKS;
    localparam int STEP_W    = $clog2(STEP_MAX + 1);

    phase_e            phase;
    logic [STEP_W-1:0] step;
    logic              tick;
    logic              restart;

    sar_tick_gen #(
        .SEL_W (SEL_W)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .sel_i     (presc_sel_i),
        .tick_o    (tick)
    );

    sar_phase_ctrl #(
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .BITS         (BITS),
        .CAL_TICKS    (CAL_TICKS),
        .STEP_W       (STEP_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cont_i       (cont_i),
        .irq_clr_i    (irq_clr_i),
        .tick_i       (tick),
        .phase_o      (phase),
        .step_o       (step),
        .restart_o    (restart),
        .busy_o       (busy_o),
        .irq_o        (irq_o),
        .sample_o     (sample_o),
        .cal_offset_o (cal_offset_o),
        .cal_lin_o    (cal_lin_o)
    );

    sar_approx_reg #(
        .BITS   (BITS),
        .STEP_W (STEP_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .tick_i   (tick),
        .step_i   (step),
        .cmp_i    (cmp_i),
        .trial_o  (dac_code_o),
        .result_o (result_o)
    );

endmodule

// File: tb/sar_seq_tb.sv
// Bench: a driver queues expected conversions, and a falling-edge monitor
// checks them against the ports as each conversion completes.
module sar_seq_tb;

    typedef struct {
        logic [9:0] code;
        int         len;
        int         d;
        bit         lin;
        bit         cont;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cont_i = 1'b0;
    logic [1:0] presc_sel_i = 2'd0;
    logic       irq_clr_i = 1'b0;
    logic       cmp_i;
    logic [9:0] dac_code_o;
    logic       sample_o, busy_o, irq_o, cal_offset_o, cal_lin_o;
    logic [9:0] result_o;
    logic [9:0] vin = 10'd0;

    int   total = 0;
    int   fails = 0;
    int   done_cnt = 0;
    int   cycles = 0;
    bit   cal_lin_next = 1'b0;
    exp_t expq[$];

    always #10 clk = ~clk;

    // Ideal comparator model: input at or above the trial code.
    assign cmp_i = (vin >= dac_code_o);

    sar_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cont_i       (cont_i),
        .presc_sel_i  (presc_sel_i),
        .irq_clr_i    (irq_clr_i),
        .cmp_i        (cmp_i),
        .dac_code_o   (dac_code_o),
        .sample_o     (sample_o),
        .busy_o       (busy_o),
        .irq_o        (irq_o),
        .result_o     (result_o),
        .cal_offset_o (cal_offset_o),
        .cal_lin_o    (cal_lin_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            report();
        end
    end

    // Monitor state
    bit         prev_busy = 1'b0;
    bit         res_pending = 1'b0;
    bit         got_trial = 1'b0;
    int         busy_cnt, samp_cnt, off_cnt, lin_cnt, hold_err;
    logic [9:0] first_trial;
    logic [9:0] last_result = 10'd0;
    exp_t       cur;

    // Monitor: count busy windows and check each finished conversion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_pending) begin
                res_pending = 1'b0;
                check(result_o == cur.code, "R3 result equals input", result_o, cur.code);
                check(busy_o == cur.cont, "R8 busy after write", busy_o, cur.cont);
                last_result = result_o;
                done_cnt++;
            end
            if (busy_o) begin
                if (!prev_busy) begin
                    busy_cnt = 0; samp_cnt = 0; off_cnt = 0; lin_cnt = 0;
                    hold_err = 0; got_trial = 1'b0; first_trial = '0;
                    check(sample_o == 1'b1, "R2 sample at start", sample_o, 1);
                end
                busy_cnt++;
                if (sample_o) samp_cnt++;
                if (cal_offset_o) off_cnt++;
                if (cal_lin_o) lin_cnt++;
                if (result_o != last_result) hold_err++;
                if (!got_trial && dac_code_o != '0) begin
                    got_trial = 1'b1;
                    first_trial = dac_code_o;
                end
            end else if (prev_busy) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R10 unexpected conversion", 1, 0);
                    cur = '{code: 10'd0, len: 0, d: 1, lin: 1'b0, cont: 1'b0};
                end else begin
                    cur = expq.pop_front();
                end
                check(busy_cnt == cur.len, "R4 busy length", busy_cnt, cur.len);
                check(irq_o == 1'b1, "R5 irq at busy fall", irq_o, 1);
                check(samp_cnt == 4 * cur.d, "R2 sample length", samp_cnt, 4 * cur.d);
                check(first_trial == 10'h200, "R3 first trial", first_trial, 10'h200);
                check(hold_err == 0, "R6 result held during busy", hold_err, 0);
                check(result_o == last_result, "R6 result not yet written", result_o, last_result);
                if (cur.lin)
                    check(lin_cnt == 2 * cur.d && off_cnt == 0, "R7 linearity window", lin_cnt, 2 * cur.d);
                else
                    check(off_cnt == 2 * cur.d && lin_cnt == 0, "R7 offset window", off_cnt, 2 * cur.d);
                res_pending = 1'b1;
            end
            prev_busy = busy_o;
        end
    end

    // Queue one expected conversion.
    task automatic push_exp(input logic [9:0] v, input int sel, input bit c);
        exp_t e;
        e.code = v;
        e.d    = 1 << sel;
        e.len  = 16 * (1 << sel);
        e.lin  = cal_lin_next;
        e.cont = c;
        cal_lin_next = !cal_lin_next;
        expq.push_back(e);
    endtask

    // Clear the interrupt flag from idle and check that it clears.
    task automatic clear_irq();
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        check(irq_o == 1'b0, "R9 clear", irq_o, 0);
    endtask

    // Driver: one single-mode conversion with optional late select and busy start.
    task automatic run_conv(input logic [9:0] v, input int sel, input int late_sel, input bit poke);
        int prev;
        int seen;
        clear_irq();
        vin = v;
        presc_sel_i = 2'(sel);
        cont_i = 1'b0;
        push_exp(v, sel, 1'b0);
        prev = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        presc_sel_i = 2'(late_sel);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (done_cnt == prev + 1);
        @(negedge clk);
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy_o) seen++;
        end
        check(seen == 0, poke ? "R10 busy start ignored" : "R8 single stays idle", seen, 0);
        check(irq_o == 1'b1, "R9 irq sticky", irq_o, 1);
    endtask

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(busy_o == 0 && irq_o == 0 && sample_o == 0, "R1 flags", {busy_o, irq_o, sample_o}, 0);
        check(result_o == 0 && dac_code_o == 0, "R1 codes", result_o, 0);
        check(cal_offset_o == 0 && cal_lin_o == 0, "R1 cal", {cal_offset_o, cal_lin_o}, 0);

        run_conv(10'h2AA, 0, 0, 1'b0);
        run_conv(10'h155, 1, 1, 1'b0);
        run_conv(10'h3FF, 2, 2, 1'b0);
        run_conv(10'h000, 3, 3, 1'b0);
        // R11: a select change mid-conversion waits for the next start
        run_conv(10'h200, 1, 3, 1'b0);
        run_conv(10'h1FF, 3, 3, 1'b0);
        // R10: a start while busy
        run_conv(10'h0F0, 0, 0, 1'b1);

        // R9: a clear in the cycle of the set loses
        clear_irq();
        vin = 10'h101;
        presc_sel_i = 2'd0;
        push_exp(10'h101, 0, 1'b0);
        prev = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (15) @(negedge clk);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        check(irq_o == 1'b1, "R9 set wins over clear", irq_o, 1);
        wait (done_cnt == prev + 1);
        @(negedge clk);

        // R8: continuous mode restarts, then single mode stops
        clear_irq();
        vin = 10'h333;
        cont_i = 1'b1;
        presc_sel_i = 2'd0;
        push_exp(10'h333, 0, 1'b1);
        push_exp(10'h0CC, 0, 1'b0);
        prev = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (done_cnt == prev + 1);
        cont_i = 1'b0;
        vin = 10'h0CC;
        wait (done_cnt == prev + 2);
        repeat (5) @(negedge clk);
        check(busy_o == 1'b0, "R8 continuous ends in single", busy_o, 0);
        check(expq.size() == 0, "R4 all conversions seen", expq.size(), 0);
        report();
    end

endmodule